// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns single-word read and write requests from a simple processor-side port into the strobe sequences of a DRAM device. The device has one shared address bus. Each request address is split into a row part and a column part. The row goes out first and is latched by a falling RAS. The column follows and is latched by a falling CAS.

After an access, the row stays open with RAS held low. A later request to the same row needs only a new column strobe. A request to a different row first closes the open row with a precharge and then activates the new one.

A refresh timer runs from the clock-frequency parameter. Every 15.625 us it requests a RAS-only refresh of the next row in rotation. A refresh never breaks into an access the sequencer has already accepted. It waits for that access to complete and leaves no row open afterwards. All device timings are whole clock cycles set by parameters. The read latency must satisfy CAS_LAT <= T_CAS + 1.

Top module: `dram_page_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, dram_ras_n_o, dram_cas_n_o and dram_we_n_o are high, dram_dq_oe_o and rd_valid_o are low, and req_ready_o is high.
- R2: The row is the upper ROW_W bits of req_addr_i and the column is the lower COL_W bits. The row is on dram_addr_o in the first cycle RAS is low, and the column is on dram_addr_o in the first cycle CAS is low. CAS is only ever low while RAS is low.
- R3: When a row is activated for a request, CAS falls exactly T_RCD cycles after RAS falls.
- R4: Every CAS low pulse lasts exactly T_CAS cycles.
- R5: Between RAS rising and its next fall, RAS stays high at least T_RP cycles.
- R6: A request to the row that is currently open produces a CAS pulse with no RAS transition between acceptance and the end of that pulse.
- R7: A request to a row other than the open one raises RAS (precharge) before activating the new row.
- R8: A write (req_we_i = 1) holds dram_we_n_o low, dram_dq_oe_o high and dram_dq_o equal to the write data for the whole CAS pulse. A read keeps dram_we_n_o high and dram_dq_oe_o low. Outside CAS pulses, dram_we_n_o is high and dram_dq_oe_o is low.
- R9: Each read gives exactly one rd_valid_o pulse, CAS_LAT cycles after its CAS falls. rd_data_o carries the word the device returns for that address.
- R10: Refresh ticks recur every floor(CLK_KHZ*15625/1e6) cycles. Up to two ticks may be pending at once. Refreshes issued after N cycles number between N/interval - 2 and N/interval.
- R11: A refresh is a RAS pulse with CAS high. Its dram_addr_o is the refresh row, which starts at 0 and increases by one per refresh, wrapping modulo 2^ROW_W.
- R12: A refresh never raises RAS while an accepted access has been activated or hit but has not finished its CAS pulse. After a refresh no row is open, so the next request is activated anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Word address {row, column} |
| req_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | One-cycle read data strobe |
| rd_data_o | output | DATA_W | Read data |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Data to device |
| dram_dq_oe_o | output | 1 | Data drive enable |
| dram_dq_i | input | DATA_W | Data from device |

## Verification
Two functions can land in the same cycle: a refresh tick, and the acceptance of a request or a column phase in progress. The bench streams a long pseudo-random mix of same-row and cross-row accesses, so that many refresh ticks fall on an accept edge or inside an access. It also leaves idle gaps, so that other ticks find a row held open. The cycle-accurate bench model records every accepted access. It flags any RAS rise between activation and the end of that access's CAS pulse. It checks that the refresh rows stay in sequence, that the next access after a refresh is activated again, and that the total refresh count keeps pace with the interval.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CAS,
    ST_OPEN,
    ST_PRE,
    ST_REF
  } dpc_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
  parameter int REF_CYC = 1562,
  parameter int ROW_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  output logic [1:0]       pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int RC_W = (REF_CYC > 2) ? $clog2(REF_CYC) : 1;

  logic [RC_W-1:0] cnt_q;
  logic            tick;

  assign tick = (cnt_q == RC_W'(REF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // pending count saturates at two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else begin
      unique case ({tick, done_i})
        2'b10:   pend_o <= (pend_o == 2'd2) ? 2'd2 : pend_o + 2'd1;
        2'b01:   pend_o <= pend_o - 2'd1;
        default: pend_o <= pend_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_o <= '0;
    else if (done_i) row_o <= row_o + 1'b1;
  end

  a_r10_pend_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o <= 2'd2);
endmodule

// File: rtl/dpc_rd_pipe.sv
module dpc_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CAS_LAT-1:0] st_q;
  logic               cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else st_q <= CAS_LAT'({st_q, issue_i});
  end

  generate
    if (CAS_LAT == 1) begin : g_lat1
      assign cap = issue_i;
    end else begin : g_latn
      assign cap = st_q[CAS_LAT-2];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else if (cap) data_o <= dq_i;
  end

  assign valid_o = st_q[CAS_LAT-1];

  a_r9_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(st_q));
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int T_RFC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  input  logic [1:0]        ref_pend_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic              ref_done_o,
  output logic              rd_issue_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [max2(ROW_W, COL_W)-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int ADDR_W = max2(ROW_W, COL_W);
  localparam int TMAX   = max2(max2(T_RCD, T_CAS), max2(T_RP, T_RFC));
  localparam int CNT_W  = $clog2(TMAX + 1);

  dpc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q, open_row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q, miss_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ref_due;

  assign ref_due     = (ref_pend_i != 2'd0);
  assign req_ready_o = ((state_q == ST_IDLE) || (state_q == ST_OPEN)) && !ref_due;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      row_q      <= '0;
      col_q      <= '0;
      open_row_q <= '0;
      we_q       <= 1'b0;
      miss_q     <= 1'b0;
      wdata_q    <= '0;
      ref_done_o <= 1'b0;
      rd_issue_o <= 1'b0;
      ras_n_o    <= 1'b1;
      cas_n_o    <= 1'b1;
      we_n_o     <= 1'b1;
      addr_o     <= '0;
      dq_o       <= '0;
      dq_oe_o    <= 1'b0;
    end else begin
      ref_done_o <= 1'b0;
      rd_issue_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ref_due) begin
            addr_o  <= ADDR_W'(ref_row_i);
            ras_n_o <= 1'b0;
            cnt_q   <= CNT_W'(T_RFC - 1);
            state_q <= ST_REF;
          end else if (req_valid_i) begin
            row_q   <= req_row_i;
            col_q   <= req_col_i;
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
            addr_o  <= ADDR_W'(req_row_i);
            ras_n_o <= 1'b0;
            cnt_q   <= CNT_W'(T_RCD - 1);
            state_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (cnt_q == '0) begin
            addr_o     <= ADDR_W'(col_q);
            cas_n_o    <= 1'b0;
            we_n_o     <= !we_q;
            dq_oe_o    <= we_q;
            dq_o       <= wdata_q;
            rd_issue_o <= !we_q;
            open_row_q <= row_q;
            cnt_q      <= CNT_W'(T_CAS - 1);
            state_q    <= ST_CAS;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_CAS: begin
          if (cnt_q == '0) begin
            cas_n_o <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
            state_q <= ST_OPEN;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_OPEN: begin
          if (ref_due) begin
            ras_n_o <= 1'b1;
            cnt_q   <= CNT_W'(T_RP - 1);
            state_q <= ST_PRE;
          end else if (req_valid_i) begin
            row_q   <= req_row_i;
            col_q   <= req_col_i;
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
            if (req_row_i == open_row_q) begin
              addr_o     <= ADDR_W'(req_col_i);
              cas_n_o    <= 1'b0;
              we_n_o     <= !req_we_i;
              dq_oe_o    <= req_we_i;
              dq_o       <= req_wdata_i;
              rd_issue_o <= !req_we_i;
              cnt_q      <= CNT_W'(T_CAS - 1);
              state_q    <= ST_CAS;
            end else begin
              ras_n_o <= 1'b1;
              miss_q  <= 1'b1;
              cnt_q   <= CNT_W'(T_RP - 1);
              state_q <= ST_PRE;
            end
          end
        end
        ST_REF: begin
          if (cnt_q == '0) begin
            ras_n_o    <= 1'b1;
            ref_done_o <= 1'b1;
            cnt_q      <= CNT_W'(T_RP - 1);
            state_q    <= ST_PRE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_PRE: begin
          if (cnt_q == '0) begin
            if (miss_q) begin
              miss_q  <= 1'b0;
              addr_o  <= ADDR_W'(row_q);
              ras_n_o <= 1'b0;
              cnt_q   <= CNT_W'(T_RCD - 1);
              state_q <= ST_ACT;
            end else state_q <= ST_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker counters: cycles of RAS high and of CAS low
  localparam int HC_W = $clog2(T_RP + 2);
  localparam int LC_W = $clog2(T_CAS + 2);
  logic [HC_W-1:0] ras_hi_cnt;
  logic [LC_W-1:0] cas_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_hi_cnt <= HC_W'(T_RP);
      cas_lo_cnt <= '0;
    end else begin
      if (!ras_n_o) ras_hi_cnt <= '0;
      else if (ras_hi_cnt < HC_W'(T_RP)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
      if (cas_n_o) cas_lo_cnt <= '0;
      else if (cas_lo_cnt <= LC_W'(T_CAS)) cas_lo_cnt <= cas_lo_cnt + 1'b1;
    end
  end

  a_r2_cas_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o);
  a_r8_we_in_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !cas_n_o);
  a_r5_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (ras_hi_cnt >= HC_W'(T_RP)));
  a_r4_cas_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> (cas_lo_cnt == LC_W'(T_CAS)));
  a_r12_close_after_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> $past(cas_n_o));
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int DATA_W  = 8,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_RP    = 2,
  parameter int T_RFC   = 3,
  parameter int CAS_LAT = 2,
  parameter int CLK_KHZ = 100000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_we_i,
  input  logic [ROW_W+COL_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]              req_wdata_i,
  output logic                           rd_valid_o,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [max2(ROW_W, COL_W)-1:0]  dram_addr_o,
  output logic                           dram_ras_n_o,
  output logic                           dram_cas_n_o,
  output logic                           dram_we_n_o,
  output logic [DATA_W-1:0]              dram_dq_o,
  output logic                           dram_dq_oe_o,
  input  logic [DATA_W-1:0]              dram_dq_i
);
  localparam int AW       = ROW_W + COL_W;
  // 15.625 us expressed in clock cycles
  localparam longint REF_RAW = (longint'(CLK_KHZ) * 64'd15625) / 64'd1000000;
  localparam int REF_CYC  = (REF_RAW < 2) ? 2 : int'(REF_RAW);

  logic [1:0]       ref_pend;
  logic [ROW_W-1:0] ref_row;
  logic             ref_done;
  logic             rd_issue;

  dpc_refresh_timer #(.REF_CYC(REF_CYC), .ROW_W(ROW_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (ref_done),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  dpc_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RFC(T_RFC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_row_i   (req_addr_i[AW-1:COL_W]),
    .req_col_i   (req_addr_i[COL_W-1:0]),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .ref_pend_i  (ref_pend),
    .ref_row_i   (ref_row),
    .ref_done_o  (ref_done),
    .rd_issue_o  (rd_issue),
    .ras_n_o     (dram_ras_n_o),
    .cas_n_o     (dram_cas_n_o),
    .we_n_o      (dram_we_n_o),
    .addr_o      (dram_addr_o),
    .dq_o        (dram_dq_o),
    .dq_oe_o     (dram_dq_oe_o)
  );

  dpc_rd_pipe #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (rd_issue),
    .dq_i    (dram_dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RFC = 3, CAS_LAT = 2;
  localparam int CLK_KHZ = 4096;
  localparam int REF_INT = CLK_KHZ * 15625 / 1000000;  // 64 cycles
  localparam int NW = 1 << (ROW_W + COL_W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, dq_in = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out;
  logic [3:0] dram_addr;

  dram_page_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_RFC(T_RFC), .CAS_LAT(CAS_LAT), .CLK_KHZ(CLK_KHZ)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .dram_addr_o(dram_addr),
    .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
    .dram_dq_o(dq_out), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model
  logic [DATA_W-1:0] mem [NW];
  logic [DATA_W-1:0] shadow [NW];
  logic [ROW_W-1:0] m_row = '0;
  logic m_ras_p = 1'b1, m_cas_p = 1'b1;
  always @(negedge clk) begin
    if (m_ras_p && !ras_n) m_row = dram_addr[ROW_W-1:0];
    if (m_cas_p && !cas_n) begin
      if (!we_n) mem[{m_row, dram_addr[COL_W-1:0]}] = dq_out;
      else dq_in <= mem[{m_row, dram_addr[COL_W-1:0]}];
    end
    m_ras_p = ras_n;
    m_cas_p = cas_n;
  end

  // cycle-by-cycle reference model and monitor
  bit mon_en = 0, acc_seen = 0;
  int cyc = 0;
  bit ras_p = 1, cas_p = 1;
  int ras_rise_cyc = -100, ras_fall_cyc = 0, cas_fall_cyc = 0;
  bit fl_v = 0, fl_we = 0, fl_act = 0, fl_hit = 0, fl_close = 0, fl_seen_close = 0, fl_cas = 0;
  int fl_row = 0, fl_col = 0, fl_data = 0;
  bit open_v = 0, closed_by_ref = 0;
  int open_row = 0, exp_ref_row = 0, n_ref = 0, n_hit = 0, n_miss_open = 0;
  int rd_due[$], rd_dat[$];

  always @(negedge clk) if (mon_en) begin
    cyc++;
    if (ras_p && !ras_n) begin
      chk(cyc - ras_rise_cyc >= T_RP, "R5 precharge gap", cyc - ras_rise_cyc, T_RP);
      if (fl_v && fl_hit) chk(0, "R6 RAS fell during page hit", 1, 0);
      else if (fl_v && !fl_act) begin
        chk(dram_addr == fl_row, "R2 row address", dram_addr, fl_row);
        if (fl_close) chk(fl_seen_close, "R7 no precharge before new row", 0, 1);
        fl_act = 1; ras_fall_cyc = cyc; open_v = 1; open_row = fl_row; closed_by_ref = 0;
      end else begin
        chk(cas_n, "R11 CAS high in refresh", cas_n, 1);
        chk(dram_addr == exp_ref_row, "R11 refresh row", dram_addr, exp_ref_row);
        exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
        n_ref++; open_v = 0; closed_by_ref = 1;
      end
    end
    if (!ras_p && ras_n) begin
      ras_rise_cyc = cyc;
      if (fl_v && (fl_act || fl_hit)) chk(0, "R12 row closed inside access", 1, 0);
      else if (fl_v) fl_seen_close = 1;
      open_v = 0;
    end
    if (cas_p && !cas_n) begin
      chk(!ras_n, "R2 CAS without RAS", ras_n, 0);
      if (!fl_v) chk(0, "R12 CAS without request", 1, 0);
      else begin
        chk(dram_addr == fl_col, "R2 column address", dram_addr, fl_col);
        if (fl_hit) begin
          chk(!fl_act, "R6 page hit re-activated", fl_act, 0);
          n_hit++;
        end else if (!fl_act)
          chk(0, closed_by_ref ? "R12 access after refresh not activated" : "R7 missing activation", 0, 1);
        else chk(cyc - ras_fall_cyc == T_RCD, "R3 RAS to CAS", cyc - ras_fall_cyc, T_RCD);
        chk(we_n == !fl_we, "R8 write enable", we_n, !fl_we);
        if (!fl_we) begin
          chk(!dq_oe, "R8 no drive on read", dq_oe, 0);
          rd_due.push_back(cyc + CAS_LAT);
          rd_dat.push_back(fl_data);
        end
        cas_fall_cyc = cyc; fl_cas = 1;
      end
    end
    if (!cas_n && fl_v && fl_cas && fl_we)
      chk(!we_n && dq_oe && dq_out == fl_data, "R8 write data during CAS", dq_out, fl_data);
    if (!cas_p && cas_n) begin
      chk(cyc - cas_fall_cyc == T_CAS, "R4 CAS width", cyc - cas_fall_cyc, T_CAS);
      if (fl_v && fl_cas) fl_v = 0;
    end
    if (cas_n) chk(we_n && !dq_oe, "R8 idle strobes", {we_n, dq_oe}, 2);
    if (rd_due.size() > 0 && rd_due[0] == cyc) begin
      chk(rd_valid, "R9 read valid latency", rd_valid, 1);
      chk(rd_data == rd_dat[0], "R9 read data", rd_data, rd_dat[0]);
      void'(rd_due.pop_front());
      void'(rd_dat.pop_front());
    end else chk(!rd_valid, "R9 spurious read valid", rd_valid, 0);
    // acceptance at the coming edge
    if (req_valid && req_ready) begin
      chk(!fl_v, "R12 accept while busy", fl_v, 0);
      fl_v = 1; fl_we = req_we; fl_act = 0; fl_cas = 0; fl_seen_close = 0;
      fl_row = int'(req_addr[ROW_W+COL_W-1:COL_W]);
      fl_col = int'(req_addr[COL_W-1:0]);
      fl_hit = open_v && (open_row == fl_row);
      fl_close = open_v && !fl_hit;
      if (fl_close) n_miss_open++;
      if (req_we) begin
        shadow[req_addr] = req_wdata;
        fl_data = int'(req_wdata);
      end else fl_data = int'(shadow[req_addr]);
      acc_seen = 1;
    end
    ras_p = ras_n;
    cas_p = cas_n;
  end

  task automatic access(input bit we, input int row, input int col, input int data);
    @(posedge clk); #1;
    req_valid = 1; req_we = we;
    req_addr = {ROW_W'(row), COL_W'(col)};
    req_wdata = DATA_W'(data);
    do @(posedge clk); while (!acc_seen);
    acc_seen = 0;
    #1 req_valid = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NW; i++) begin
      mem[i] = DATA_W'(i * 7 + 3);
      shadow[i] = DATA_W'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && !dq_oe && !rd_valid, "R1 outputs in reset",
        {ras_n, cas_n, we_n, dq_oe, rd_valid}, 5'b11100);
    @(posedge clk); #1;
    rst_n = 1; mon_en = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !dq_oe && !rd_valid, "R1 outputs after reset",
        {ras_n, cas_n, we_n, dq_oe, rd_valid}, 5'b11100);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    access(1, 3, 1, 8'hA5);
    access(0, 3, 1, 0);
    access(1, 3, 5, 8'h3C);
    access(0, 3, 5, 0);
    access(0, 7, 2, 0);
    access(1, 7, 2, 8'h55);
    access(0, 7, 2, 0);
    repeat (80) @(posedge clk);  // refresh while row 7 is held open
    access(0, 7, 2, 0);

    lfsr = 16'hACE1;
    for (int i = 0; i < 500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[0], int'(lfsr[3:2]) + ((lfsr[9]) ? 8 : 0), int'(lfsr[7:4]), int'(lfsr[15:8]));
      if (i % 37 == 36) repeat (int'(lfsr[6:1]) + 10) @(posedge clk);
    end

    repeat (40) @(negedge clk);
    chk(n_ref >= cyc / REF_INT - 2 && n_ref <= cyc / REF_INT, "R10 refresh count",
        n_ref, cyc / REF_INT);
    chk(rd_due.size() == 0, "R9 outstanding reads", rd_due.size(), 0);
    chk(n_hit > 0, "R6 page hits exercised", n_hit, 1);
    chk(n_miss_open > 0, "R7 row changes exercised", n_miss_open, 1);
    summary();
    $finish;
  end
endmodule